// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller collects up to 32 numbered interrupt requests, latches each one into a flag on the rising edge of its request line, and picks the most urgent pending request using a fixed priority table. The chosen interrupt is presented as a vector number and an absolute vector address on a valid/ready stream. The consumer (normally the CPU's sequencer) takes one vector per handshake. Software sees the flags and enables as two 16-bit halves, plus two vector-table base pointers, through a plain register port.

Numbers 0 and 1 are the reset and nonmaskable requests. Each line is already the OR of its hardware and software triggers, and both ignore every mask. Numbers 2 to 26 are maskable. A few of them have a second source that is OR-merged into the same flag. Numbers 27 to 31 exist only as vector slots and have no hardware flag.

Back-pressure rules for the vector stream are as follows. Once `vec_valid_o` rises, the number and the address are frozen until a cycle in which `vec_ready_i` is high. That cycle completes the transfer and clears the served flag. `vec_valid_o` is then low for at least one cycle while the next winner is chosen. No new choice is made while a vector waits.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all flags, enables and both base pointers read 0, and `vec_valid_o` is low.
- R2: A flag is set on a rising edge of its combined request. Bits 7, 11, 13 and 19 OR `src_req_i` with `src_alt_i`, so a rise on one source is not seen while the other source of that bit is held high. `src_alt_i` on any other bit has no effect.
- R3: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a rising edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: Reserved bits always read 0 in flags and enables, whatever is written to them. These are bits 1:0 of the low half and bits 15:11 of the high half.
- R5: A maskable interrupt (2..26) is taken only when its flag, its enable and `gie_i` are all 1 in the cycle of choice.
- R6: Among pending requests, the winner follows this fixed order from highest to lowest: 0, 1, 24, 2, 16, 3, 4, 5, 17, 6, 7, 8, 18, 9, 10, 11, 19, 12, 13, 20, 21, 14, 15, 22, 23, 25, 26. Only numbers 0..26 are ever issued.
- R7: The vector address is {base, number, 3'b000}, so each slot is 8 bytes. The base is the alternate pointer for numbers 16..23 and the main pointer for all others.
- R8: While `vec_valid_o` is high and `vec_ready_i` is low, the number and the address are held. A transfer clears the served flag, and `vec_valid_o` is low in the next cycle.
- R9: Requests 0 and 1 are taken even with all enables and `gie_i` at 0. Request 0 beats request 1.
- R10: The register map is 0 = flags 15:0, 1 = flags 31:16, 2 = enables 15:0, 3 = enables 31:16, 4 = main base, 5 = alternate base. Bit n of the 32-bit view is interrupt n. Enables and bases read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | 32 | Request line per interrupt number (0 reset, 1 nonmaskable) |
| src_alt_i | input | 32 | Second source, used only on the shared bits |
| gie_i | input | 1 | Global enable for maskable interrupts |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| vec_valid_o | output | 1 | Vector available |
| vec_ready_i | input | 1 | Consumer accepts the vector |
| vec_num_o | output | 5 | Interrupt number |
| vec_addr_o | output | 24 | Absolute vector address |

## Verification
The assertions assume that software does not rewrite a base pointer while a vector is waiting, because the address is fixed when the vector is chosen and the pointer checks compare it against the live pointer. The bench writes both pointers once during setup and never changes them afterwards. The assertions also assume that each request pulse lasts at least one full cycle, with a low cycle between pulses. Every stimulus task drives requests at the falling edge, and each pulse lasts exactly one cycle. The consumer's ready signal is allowed to stay low for many cycles, so the hold checks are exercised with a stalled consumer.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_VEC   = 32;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int DATA_W    = 16;
  localparam int PTR_W     = 16;
  localparam int SLOT_SH   = 3;
  localparam int ADDR_W    = PTR_W + VEC_W + SLOT_SH;
  localparam int ALT_FIRST = 16;
  localparam int ALT_LAST  = 23;
  localparam int PRIO_LEN  = 27;

  localparam logic [NUM_VEC-1:0] LIVE_MASK   = 32'h07FF_FFFF;
  localparam logic [NUM_VEC-1:0] SOFT_MASK   = 32'h07FF_FFFC;
  localparam logic [NUM_VEC-1:0] BYPASS_MASK = 32'h0000_0003;
  localparam logic [NUM_VEC-1:0] SHARED_MASK = 32'h0008_2880;

  localparam logic [2:0] RA_FLAG_LO = 3'd0;
  localparam logic [2:0] RA_FLAG_HI = 3'd1;
  localparam logic [2:0] RA_EN_LO   = 3'd2;
  localparam logic [2:0] RA_EN_HI   = 3'd3;
  localparam logic [2:0] RA_BASE_M  = 3'd4;
  localparam logic [2:0] RA_BASE_A  = 3'd5;

  typedef logic [VEC_W-1:0] vec_num_t;

  localparam vec_num_t PRIO_ORDER [0:PRIO_LEN-1] = '{
    5'd0,  5'd1,  5'd24, 5'd2,  5'd16, 5'd3,  5'd4,  5'd5,  5'd17,
    5'd6,  5'd7,  5'd8,  5'd18, 5'd9,  5'd10, 5'd11, 5'd19, 5'd12,
    5'd13, 5'd20, 5'd21, 5'd14, 5'd15, 5'd22, 5'd23, 5'd25, 5'd26};
endpackage

// File: rtl/vic_flag_bank.sv
module vic_flag_bank #(
  parameter int N = 32,
  parameter logic [N-1:0] USED   = '1,
  parameter logic [N-1:0] SHARED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] alt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] merged;
  logic         unused_hi;

  assign merged    = req_i | (alt_i & SHARED);
  assign unused_hi = ^(merged & ~USED) ^ ^(clr_i & ~USED);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (USED[i]) begin : g_live
      logic prev_q, flag_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          prev_q <= merged[i];
          if (merged[i] && !prev_q) flag_q <= 1'b1;
          else if (clr_i[i])        flag_q <= 1'b0;
        end
      end
      assign flag_o[i] = flag_q;
    end else begin : g_dead
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb
  import vic_pkg::*;
(
  input  logic [NUM_VEC-1:0] pend_i,
  output logic               hit_o,
  output vec_num_t           num_o
);
  always_comb begin
    hit_o = 1'b0;
    num_o = '0;
    for (int p = 0; p < PRIO_LEN; p++) begin
      if (!hit_o && pend_i[PRIO_ORDER[p]]) begin
        hit_o = 1'b1;
        num_o = PRIO_ORDER[p];
      end
    end
  end
endmodule

// File: rtl/vic_vec_out.sv
module vic_vec_out
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  vec_num_t          num_i,
  input  logic [PTR_W-1:0]  base_main_i,
  input  logic [PTR_W-1:0]  base_alt_i,
  input  logic              ready_i,
  output logic              valid_o,
  output vec_num_t          num_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic             use_alt;
  logic [PTR_W-1:0] base_sel;

  assign use_alt  = (int'(num_i) >= ALT_FIRST) && (int'(num_i) <= ALT_LAST);
  assign base_sel = use_alt ? base_alt_i : base_main_i;
  assign done_o   = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      num_o   <= '0;
      addr_o  <= '0;
    end else if (done_o) begin
      valid_o <= 1'b0;
    end else if (!valid_o && hit_i) begin
      valid_o <= 1'b1;
      num_o   <= num_i;
      addr_o  <= {base_sel, num_i, {SLOT_SH{1'b0}}};
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_VEC-1:0]  src_req_i,
  input  logic [NUM_VEC-1:0]  src_alt_i,
  input  logic                gie_i,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                vec_valid_o,
  input  logic                vec_ready_i,
  output logic [VEC_W-1:0]    vec_num_o,
  output logic [ADDR_W-1:0]   vec_addr_o
);
  logic [NUM_VEC-1:0] flags, en_q, clr_sw, clr_ack, pend;
  logic [PTR_W-1:0]   base_main_q, base_alt_q;
  logic               hit, done;
  vec_num_t           win_num;

  always_comb begin
    clr_sw = '0;
    if (reg_we_i && reg_addr_i == RA_FLAG_LO) clr_sw[DATA_W-1:0]       = reg_wdata_i;
    if (reg_we_i && reg_addr_i == RA_FLAG_HI) clr_sw[NUM_VEC-1:DATA_W] = reg_wdata_i;
    clr_sw = clr_sw & SOFT_MASK;
  end

  assign clr_ack = done ? (NUM_VEC'(1) << vec_num_o) : '0;

  vic_flag_bank #(.N(NUM_VEC), .USED(LIVE_MASK), .SHARED(SHARED_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .req_i(src_req_i), .alt_i(src_alt_i),
    .clr_i(clr_sw | clr_ack), .flag_o(flags));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= '0;
      base_main_q <= '0;
      base_alt_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_EN_LO:  en_q[DATA_W-1:0]       <= reg_wdata_i & SOFT_MASK[DATA_W-1:0];
        RA_EN_HI:  en_q[NUM_VEC-1:DATA_W] <= reg_wdata_i & SOFT_MASK[NUM_VEC-1:DATA_W];
        RA_BASE_M: base_main_q <= reg_wdata_i;
        RA_BASE_A: base_alt_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  assign pend = flags & ((en_q & SOFT_MASK & {NUM_VEC{gie_i}}) | BYPASS_MASK);

  vic_prio_arb u_arb (.pend_i(pend), .hit_o(hit), .num_o(win_num));

  vic_vec_out u_out (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .num_i(win_num),
    .base_main_i(base_main_q), .base_alt_i(base_alt_q), .ready_i(vec_ready_i),
    .valid_o(vec_valid_o), .num_o(vec_num_o), .addr_o(vec_addr_o), .done_o(done));

  always_comb begin
    case (reg_addr_i)
      RA_FLAG_LO: reg_rdata_o = flags[DATA_W-1:0]       & SOFT_MASK[DATA_W-1:0];
      RA_FLAG_HI: reg_rdata_o = flags[NUM_VEC-1:DATA_W] & SOFT_MASK[NUM_VEC-1:DATA_W];
      RA_EN_LO:   reg_rdata_o = en_q[DATA_W-1:0];
      RA_EN_HI:   reg_rdata_o = en_q[NUM_VEC-1:DATA_W];
      RA_BASE_M:  reg_rdata_o = base_main_q;
      RA_BASE_A:  reg_rdata_o = base_alt_q;
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic              ready,
  input logic [VEC_W-1:0]  num,
  input logic [ADDR_W-1:0] addr,
  input logic              gie,
  input logic [2:0]        raddr,
  input logic [DATA_W-1:0] rdata,
  input logic [PTR_W-1:0]  base_main,
  input logic [PTR_W-1:0]  base_alt
);
  logic in_alt;
  assign in_alt = (int'(num) >= ALT_FIRST) && (int'(num) <= ALT_LAST);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(num) && $stable(addr));

  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready |=> !valid);

  assert_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) && num > 5'd1 |-> $past(gie));

  assert_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> addr[VEC_W+SLOT_SH-1:0] == {num, {SLOT_SH{1'b0}}});

  assert_base_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && in_alt |-> addr[ADDR_W-1:VEC_W+SLOT_SH] == base_alt);

  assert_base_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !in_alt |-> addr[ADDR_W-1:VEC_W+SLOT_SH] == base_main);

  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> int'(num) < PRIO_LEN);

  assert_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr == RA_FLAG_HI || raddr == RA_EN_HI) |-> rdata[15:11] == 5'd0);
endmodule

bind vec_irq_ctrl vic_checker u_chk (
  .clk(clk), .rst_n(rst_n), .valid(vec_valid_o), .ready(vec_ready_i),
  .num(vec_num_o), .addr(vec_addr_o), .gie(gie_i), .raddr(reg_addr_i),
  .rdata(reg_rdata_o), .base_main(base_main_q), .base_alt(base_alt_q));

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0, src_alt = '0;
  logic        gie = 1'b0, we = 1'b0, ready = 1'b0;
  logic [2:0]  raddr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        vvalid;
  logic [4:0]  vnum;
  logic [23:0] vaddr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct packed { logic [4:0] num; logic [23:0] addr; } exp_t;
  exp_t sbq[$];

  always #(CLK_P/2) clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .src_alt_i(src_alt),
    .gie_i(gie), .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .vec_valid_o(vvalid), .vec_ready_i(ready),
    .vec_num_o(vnum), .vec_addr_o(vaddr));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    raddr = a;
    #1;
    check(rdata == exp, req, {16'h0, rdata}, {16'h0, exp});
  endtask

  task automatic pulse(input logic [31:0] m, input logic [31:0] alt_m);
    src_req = src_req | m; src_alt = src_alt | alt_m;
    @(negedge clk);
    src_req = src_req & ~m; src_alt = src_alt & ~alt_m;
  endtask

  task automatic push(input logic [4:0] n, input logic [23:0] a);
    exp_t e;
    e.num = n; e.addr = a;
    sbq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops one expected vector per completed transfer (R6, R7)
  always @(negedge clk) begin
    if (rst_n && vvalid && ready) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R6 unexpected vector", {3'b0, vnum, vaddr}, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(vnum == e.num && vaddr == e.addr, "R6/R7 vector",
              {3'b0, vnum, vaddr}, {3'b0, e.num, e.addr});
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(vvalid == 1'b0, "R1 valid", {31'h0, vvalid}, 32'h0);
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 16'h0000, "R1 reset reg");
    // R10 map, R4 reserved bits
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'h1234);
    wr(3'd5, 16'hABCD);
    rd_chk(3'd2, 16'hFFFC, "R4 enable low reserved");
    rd_chk(3'd3, 16'h07FF, "R4 enable high reserved");
    rd_chk(3'd4, 16'h1234, "R10 main base");
    rd_chk(3'd5, 16'hABCD, "R10 alt base");
    // R5: gie low blocks a flagged, enabled request
    ready = 1'b1;
    pulse(32'h0000_0010, 32'h0);
    idle(4);
    check(vvalid == 1'b0, "R5 gie low", {31'h0, vvalid}, 32'h0);
    rd_chk(3'd0, 16'h0010, "R10 flag bit 4");
    wr(3'd2, 16'h0000);
    gie = 1'b1;
    idle(4);
    check(vvalid == 1'b0, "R5 enable low", {31'h0, vvalid}, 32'h0);
    push(5'd4, 24'h123420);
    wr(3'd2, 16'h0010);
    idle(6);
    check(sbq.size() == 0, "R5 taken when all set", sbq.size(), 32'h0);
    rd_chk(3'd0, 16'h0000, "R8 auto clear bit 4");
    // R6/R8: several at once under back-pressure
    wr(3'd2, 16'hFFFF);
    ready = 1'b0;
    push(5'd24, 24'h1234C0);
    push(5'd16, 24'hABCD80);
    push(5'd3,  24'h123418);
    push(5'd5,  24'h123428);
    pulse(32'h0101_0028, 32'h0);
    idle(6);
    check(vvalid && vnum == 5'd24, "R8 held under stall", {27'h0, vnum}, 32'd24);
    ready = 1'b1;
    idle(14);
    check(sbq.size() == 0, "R6 all served", sbq.size(), 32'h0);
    rd_chk(3'd0, 16'h0000, "R8 flags low cleared");
    rd_chk(3'd1, 16'h0000, "R8 flags high cleared");
    // R9: reset and nonmaskable bypass masks
    gie = 1'b0;
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);
    push(5'd0, 24'h123400);
    push(5'd1, 24'h123408);
    pulse(32'h0000_0003, 32'h0);
    idle(8);
    check(sbq.size() == 0, "R9 bypass served", sbq.size(), 32'h0);
    // R3: set beats same-cycle clear, write 0 has no effect
    src_req[9] = 1'b1;
    wr(3'd0, 16'h0200);
    src_req[9] = 1'b0;
    rd_chk(3'd0, 16'h0200, "R3 set wins");
    wr(3'd0, 16'h0000);
    rd_chk(3'd0, 16'h0200, "R3 write zero");
    wr(3'd0, 16'h0200);
    rd_chk(3'd0, 16'h0000, "R3 write one clears");
    // R2: shared bit 7, held partner hides edge
    src_req[7] = 1'b1;
    @(negedge clk);
    rd_chk(3'd0, 16'h0080, "R2 primary edge");
    wr(3'd0, 16'h0080);
    pulse(32'h0, 32'h0000_0080);
    rd_chk(3'd0, 16'h0000, "R2 hidden by held partner");
    src_req[7] = 1'b0;
    @(negedge clk);
    pulse(32'h0, 32'h0000_0280);
    rd_chk(3'd0, 16'h0080, "R2 alt edge, non-shared alt ignored");
    wr(3'd0, 16'h0080);
    idle(2);
    check(sbq.size() == 0, "R6 queue empty", sbq.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule